// File: doc/BRIEF.md
# Comparator Edge Flag Status Register

This block holds the digital status and interrupt state for an analog comparator. The comparator's output arrives asynchronously and is first re-timed by a short flop chain. The block then watches the re-timed level for changes. A low-to-high change sets a sticky "went high" flag, and a high-to-low change sets a sticky "went low" flag. Software clears either flag by writing a one to its bit. Each flag has its own interrupt enable bit, and the enabled flags are ORed onto a single interrupt line.

Operation is governed by a small mode state machine whose state register follows the enable, stop and stop-select inputs with one cycle of lag. The states are OFF, RUN, STOP_EDGE and STOP_LEVEL. The transitions are:
- **power_up**: OFF to RUN, when enable is seen high.
- **enter_stop**: RUN to STOP_EDGE or STOP_LEVEL, when stop is seen high; the select input picks which of the two.
- **leave_stop**: either stop state back to RUN, when stop drops.
- **reselect**: between STOP_EDGE and STOP_LEVEL, when the select input changes during stop.
- **shut_down**: any state to OFF, when enable drops.

In OFF the flags are held at zero and nothing is detected. In STOP_LEVEL the flags stop reacting to changes and instead follow the level: "went high" sets while the re-timed output is high, and "went low" sets while it is low. This is the setting to use when the clock may be gated in stop.

The register is reached through a plain port with an address, write data, a write strobe and combinational read data. Exactly one address is decoded.

Top module: `cmp_flag_stat`

## Requirements
- R1: In RUN, a low-to-high change of the re-timed comparator output sets the "went high" flag (register bit 2), and the flag stays set until it is cleared.
- R2: In RUN, a high-to-low change of the re-timed comparator output sets the "went low" flag (register bit 1), and the flag stays set until it is cleared.
- R3: A write with a one in bit 1 or bit 2 clears the matching flag. A zero written to a flag bit leaves that flag unchanged.
- R4: When a flag's set condition and a write clearing that flag fall in the same cycle, the flag ends up set.
- R5: `irq_o` is high exactly when (bit 2 AND the rise enable, bit 4) or (bit 1 AND the fall enable, bit 3) holds. Both enable bits are written by register writes and read back.
- R6: While enabled, bit 0 reads the re-timed comparator output, available two clock edges after the input changes. Writes to bit 0 have no effect.
- R7: While `enable_i` is low, bit 0 reads `invert_i`, both flags read zero, and comparator changes set no flag.
- R8: In stop with `stop_edge_i` = 1 (STOP_EDGE), the flags keep their edge behaviour and do not set while the level is steady.
- R9: In stop with `stop_edge_i` = 0 (STOP_LEVEL), "went high" is set while the output is high and "went low" while it is low, so a clear has no lasting effect while that level persists.
- R10: Bits 7..5 read as zero. Any address other than `STAT_ADDR` (default 0) reads as zero, and writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw_i | input | 1 | Asynchronous comparator output |
| enable_i | input | 1 | Module enable |
| invert_i | input | 1 | Polarity-invert setting; read on bit 0 while disabled |
| stop_i | input | 1 | Low-power stop mode active |
| stop_edge_i | input | 1 | Stop-mode sensitivity: 1 = edge, 0 = level |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_we_i | input | 1 | Write strobe |
| reg_rdata_o | output | DATA_W | Read data (combinational) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The two functions that can collide are the set of a flag by a detected edge and its write-one-to-clear. The bench schedules a "went high" edge so that its set condition lies in the cycle before a particular clock edge. It then places a write clearing bit 2 on exactly that edge. The read-back afterwards must still show the flag set, and a later clear with no edge pending must succeed. STOP_LEVEL produces the same collision on every cycle, and there the bench checks that a clear cannot remove a flag whose level is still present.

// File: rtl/cmp_flag_pkg.sv
package cmp_flag_pkg;

    typedef enum logic [1:0] {
        ST_OFF        = 2'd0,
        ST_RUN        = 2'd1,
        ST_STOP_EDGE  = 2'd2,
        ST_STOP_LEVEL = 2'd3
    } cmp_mode_e;

    // register bit positions
    localparam int BIT_OUT      = 0;
    localparam int BIT_FLAG_LO  = 1;  // went low; went high is BIT_FLAG_LO + 1
    localparam int BIT_IE_LO    = 3;  // fall enable; rise enable is BIT_IE_LO + 1
    localparam int NUM_FLAGS    = 2;
    localparam int USED_BITS    = 5;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign prev_o = prev_q;

    // the delayed copy trails the synchronized level by one cycle (R1, R2)
    p_prev_trails_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_o) |=> prev_o);

endmodule

// File: rtl/cmp_mode_fsm.sv
module cmp_mode_fsm
    import cmp_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable_i,
    input  logic      stop_i,
    input  logic      stop_edge_i,
    output cmp_mode_e mode_o,
    output logic      edge_en_o,
    output logic      level_en_o
);
    cmp_mode_e state_q, state_d;
    cmp_mode_e stop_pick;

    assign stop_pick = stop_edge_i ? ST_STOP_EDGE : ST_STOP_LEVEL;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enable_i) state_d = ST_RUN;                  // power_up
            end
            ST_RUN: begin
                if (!enable_i)   state_d = ST_OFF;               // shut_down
                else if (stop_i) state_d = stop_pick;            // enter_stop
            end
            ST_STOP_EDGE, ST_STOP_LEVEL: begin
                if (!enable_i)   state_d = ST_OFF;               // shut_down
                else if (!stop_i) state_d = ST_RUN;              // leave_stop
                else             state_d = stop_pick;            // reselect
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        edge_en_o  = 1'b0;
        level_en_o = 1'b0;
        unique case (state_q)
            ST_OFF:        ;
            ST_RUN:        edge_en_o  = 1'b1;
            ST_STOP_EDGE:  edge_en_o  = 1'b1;
            ST_STOP_LEVEL: level_en_o = 1'b1;
            default:       ;
        endcase
    end

    assign mode_o = state_q;

    p_off_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> mode_o == ST_OFF);
    p_level_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && stop_i && !stop_edge_i && mode_o != ST_OFF) |=> mode_o == ST_STOP_LEVEL);
    p_edge_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && stop_i && stop_edge_i && mode_o != ST_OFF) |=> mode_o == ST_STOP_EDGE);

endmodule

// File: rtl/cmp_flag_cell.sv
module cmp_flag_cell
    import cmp_flag_pkg::*;
#(
    parameter bit POL = 1'b1   // 1: went-high flag, 0: went-low flag
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cmp_mode_e mode_i,
    input  logic      edge_en_i,
    input  logic      level_en_i,
    input  logic      lvl_i,
    input  logic      prev_i,
    input  logic      clr_i,
    output logic      flag_o
);
    logic set_w;
    logic flag_q;

    assign set_w = (edge_en_i  && (lvl_i != prev_i) && (lvl_i == POL)) ||
                   (level_en_i && (lvl_i == POL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (mode_i == ST_OFF) flag_q <= 1'b0;
        else if (set_w)            flag_q <= 1'b1;   // set beats clear
        else if (clr_i)            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w && clr_i) |=> flag_o);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_w) |=> !flag_o);
    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i && mode_i != ST_OFF) |=> flag_o);
    p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ST_OFF) |=> !flag_o);

endmodule

// File: rtl/cmp_flag_stat.sv
module cmp_flag_stat
    import cmp_flag_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int STAT_ADDR = 0,
    parameter int SYNC_LEN  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_raw_i,
    input  logic              enable_i,
    input  logic              invert_i,
    input  logic              stop_i,
    input  logic              stop_edge_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic              reg_we_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STAT_ADDR);

    logic                 lvl, prev;
    logic                 edge_en, level_en;
    cmp_mode_e            mode;
    logic                 hit, wr;
    logic [NUM_FLAGS-1:0] flags, ie_q, clr;

    assign hit = (reg_addr_i == HIT_ADDR);
    assign wr  = reg_we_i && hit;

    cmp_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (cmp_raw_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    cmp_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .stop_i      (stop_i),
        .stop_edge_i (stop_edge_i),
        .mode_o      (mode),
        .edge_en_o   (edge_en),
        .level_en_o  (level_en)
    );

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            assign clr[i] = wr && reg_wdata_i[BIT_FLAG_LO + i];
            cmp_flag_cell #(.POL(i == 1)) u_cell (
                .clk        (clk),
                .rst_n      (rst_n),
                .mode_i     (mode),
                .edge_en_i  (edge_en),
                .level_en_i (level_en),
                .lvl_i      (lvl),
                .prev_i     (prev),
                .clr_i      (clr[i]),
                .flag_o     (flags[i])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ie_q <= '0;
        else if (wr) ie_q <= reg_wdata_i[BIT_IE_LO +: NUM_FLAGS];
    end

    always_comb begin
        reg_rdata_o = '0;
        if (hit) begin
            reg_rdata_o[BIT_OUT]                   = enable_i ? lvl : invert_i;
            reg_rdata_o[BIT_FLAG_LO +: NUM_FLAGS]  = flags;
            reg_rdata_o[BIT_IE_LO +: NUM_FLAGS]    = ie_q;
        end
    end

    assign irq_o = |(flags & ie_q);

    p_irq_needs_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ie_q != '0));
    p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_OFF) |=> !irq_o);
    p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> reg_rdata_o == '0);
    p_ie_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ie_q));

endmodule

// File: tb/sim_cmp_flag_stat.sv
module sim_cmp_flag_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw = 1'b0, en = 1'b0, inv = 1'b0, stp = 1'b0, sel = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       we = 1'b0;
    logic [7:0] rdata;
    logic       irq;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    cmp_flag_stat u0 (
        .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .enable_i(en), .invert_i(inv),
        .stop_i(stp), .stop_edge_i(sel), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_we_i(we), .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk8(tag, rdata, exp);
        addr = 2'd0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 2'd0; wdata = 8'd0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rd("R7 reset state", 2'd0, 8'h00);
        chk8("R5 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        cyc(2);
        // R7: disabled, out bit follows invert, toggles set nothing
        inv = 1'b1; #1;
        rd("R7 invert readback", 2'd0, 8'h01);
        raw = 1'b1; cyc(5); raw = 1'b0; cyc(5);
        rd("R7 no detect while off", 2'd0, 8'h01);
        inv = 1'b0;
        en = 1'b1; cyc(5);
        rd("R6 enabled low", 2'd0, 8'h00);
        // R6 latency: level visible two edges after change
        raw = 1'b1; cyc(1);
        rd("R6 one edge not yet", 2'd0, 8'h00);
        cyc(1);
        rd("R6 two edges visible", 2'd0, 8'h01);
        cyc(3);
        rd("R1 rise flag", 2'd0, 8'h05);
        raw = 1'b0; cyc(5);
        rd("R2 fall flag", 2'd0, 8'h06);
        wr(2'd0, 8'h00);
        rd("R3 write zero no effect", 2'd0, 8'h06);
        wr(2'd0, 8'h01);
        rd("R6 write out bit ignored", 2'd0, 8'h06);
        wr(2'd0, 8'h02);
        rd("R3 clear fall", 2'd0, 8'h04);
        wr(2'd0, 8'h04);
        rd("R3 clear rise", 2'd0, 8'h00);
        // R10: other addresses
        for (int a = 1; a < 4; a++) begin
            wr(a[1:0], 8'hFF);
            rd("R10 other addr reads zero", a[1:0], 8'h00);
            rd("R10 other addr write ignored", 2'd0, 8'h00);
        end
        // R5 sweep over both enables and flag combinations
        for (int ie = 0; ie < 4; ie++) begin
            logic [7:0] base;
            base = 8'(ie << 3);
            wr(2'd0, base | 8'h06);
            rd("R5 enables readback", 2'd0, base);
            chk8("R5 irq no flags", {7'd0, irq}, 8'h00);
            raw = 1'b1; cyc(5);
            rd("R1 rise in sweep", 2'd0, base | 8'h05);
            chk8("R5 irq rise only", {7'd0, irq}, {7'd0, ie[1]});
            raw = 1'b0; cyc(5);
            rd("R2 fall in sweep", 2'd0, base | 8'h06);
            chk8("R5 irq both", {7'd0, irq}, {7'd0, ie[1] | ie[0]});
            wr(2'd0, base | 8'h04);
            chk8("R5 irq fall only", {7'd0, irq}, {7'd0, ie[0]});
        end
        wr(2'd0, 8'h06);
        rd("R10 high bits zero", 2'd0, 8'h00);
        // R4: clear lands on the edge where the rise sets
        raw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 2'd0; wdata = 8'h04; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = 8'h00;
        rd("R4 set beats clear", 2'd0, 8'h05);
        wr(2'd0, 8'h04);
        rd("R4 later clear works", 2'd0, 8'h01);
        raw = 1'b0; cyc(5);
        wr(2'd0, 8'h06);
        // R8: stop, edge-sensitive
        stp = 1'b1; sel = 1'b1; cyc(6);
        rd("R8 steady no flag", 2'd0, 8'h00);
        raw = 1'b1; cyc(5);
        rd("R8 edge sets in stop", 2'd0, 8'h05);
        wr(2'd0, 8'h06);
        rd("R8 clear in stop edge", 2'd0, 8'h01);
        // R9: stop, level-sensitive
        sel = 1'b0; cyc(3);
        rd("R9 high level sets rise", 2'd0, 8'h05);
        wr(2'd0, 8'h04);
        rd("R9 clear cannot hold", 2'd0, 8'h05);
        raw = 1'b0; cyc(5);
        rd("R9 low level sets fall", 2'd0, 8'h06);
        wr(2'd0, 8'h04);
        rd("R9 rise clears when low", 2'd0, 8'h02);
        // R7: disable clears flags
        stp = 1'b0; en = 1'b0; cyc(3);
        rd("R7 disable clears flags", 2'd0, 8'h00);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule